// File: doc/BRIEF.md
# UART Channel Interrupt Identifier

This block merges the four interrupt causes of one asynchronous serial channel into one interrupt request and one identification byte that the CPU reads. The causes are a receive error condition, received data (either a fill level reached or a character timeout), an empty transmit holding register, and a change on the modem lines. Each cause has its own enable bit. Only the most urgent enabled cause is reported. Each cause is cleared by the CPU access that belongs to it.

Neighbouring logic supplies the causes. Error, timeout and modem-change detections arrive as one-cycle event pulses, which the block latches. The received-data fill condition and the transmit-empty condition arrive as levels. CPU accesses arrive as one-cycle strobes. An output-enable bit from the modem control logic gates the interrupt pin, and loopback mode disconnects the pin.

Top module: `uirq_ident`

## Requirements
- R1: While `rst_n` is low and after its release with no stimulus, `ier_rdata` is 0x00, `iir_rdata` is 0x01 and `irq_o` is 0.
- R2: An `ier_wr` strobe stores `ier_wdata[3:0]`. Bit 0 enables received data and timeout, bit 1 enables transmit empty, bit 2 enables receive error and bit 3 enables modem change. `ier_rdata[7:4]` always read 0.
- R3: `iir_rdata[0]` is 0 when an enabled cause is pending and 1 when none is. `iir_rdata[3:1]` reports the highest pending enabled cause, from highest to lowest: receive error 011, received data level 010, timeout 110, transmit empty 001, modem change 000.
- R4: A `to_evt` pulse is ignored while `fifo_mode` is 0, and `iir_rdata[3]` then reads 0. With `fifo_mode` at 1, a `to_evt` pulse latches a timeout cause, shown from the next cycle.
- R5: An `ls_evt` pulse latches the receive error cause from the next cycle. A `lsr_rd` strobe clears it.
- R6: The received data cause follows `rx_level` in the same cycle, with no latching. A `rbr_rd` strobe clears the latched timeout.
- R7: A rising edge of `thr_empty` latches the transmit empty cause. It is cleared by a `thr_wr` strobe, or by an `iir_rd` strobe in a cycle whose `iir_rdata` reports transmit empty. An `iir_rd` that reports another cause leaves it pending.
- R8: An `ms_evt` pulse latches the modem change cause. A `msr_rd` strobe clears it.
- R9: A disabled cause still latches. It affects neither `iir_rdata` nor `irq_o` until its enable bit is set.
- R10: `irq_o` is 1 exactly when an enabled cause is pending. `irq_oe` is 1 exactly when `irq_gate` is 1 and `loopback` is 0.
- R11: `iir_rdata[5:4]` read 0, and `iir_rdata[7:6]` both equal `fifo_mode`.
- R12: When an event pulse and its clear strobe arrive in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| fifo_mode | input | 1 | FIFO mode active |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| ls_evt | input | 1 | Receive error detected (pulse) |
| lsr_rd | input | 1 | Line status read strobe |
| rx_level | input | 1 | Receive data available / fill level reached (level) |
| to_evt | input | 1 | Character timeout detected (pulse) |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_wr | input | 1 | Transmit holding register write strobe |
| ms_evt | input | 1 | Modem line change detected (pulse) |
| msr_rd | input | 1 | Modem status read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification register read value |
| irq_gate | input | 1 | Interrupt pin output enable from modem control |
| loopback | input | 1 | Loopback mode active |
| irq_o | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Interrupt pin drive enable (0 means high impedance) |

## Verification
The bench sets up stacked causes so that the priority order is visible. A design that swapped data and timeout, or that ranked transmit empty above data, would show the wrong code while both causes are pending. It checks that an identification read clears only a transmit empty cause that the read actually reported. An eager design would lose a transmit empty cause that was hidden behind a receive error. It checks that timeout pulses are dropped in character mode, that pulses on disabled causes stay latched until the enable bit is set, and that a pulse arriving with its own clear strobe wins. A long random phase compares every output against a behavioural model on every clock, which also catches a design that loses a pin-enable or loopback condition.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int REG_W  = 8;
  localparam int EN_W   = 4;
  localparam int NLATCH = 4;
  localparam int PAD_W  = REG_W - EN_W;

  // latch slot indices
  localparam int SL_LS = 0;
  localparam int SL_TO = 1;
  localparam int SL_TX = 2;
  localparam int SL_MS = 3;

  // enable bit positions
  localparam int EB_RX = 0;
  localparam int EB_TX = 1;
  localparam int EB_LS = 2;
  localparam int EB_MS = 3;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_LS, SRC_RX, SRC_TO, SRC_TX, SRC_MS
  } src_e;

  function automatic logic [2:0] id_bits(src_e s);
    case (s)
      SRC_LS:  return 3'b011;
      SRC_RX:  return 3'b010;
      SRC_TO:  return 3'b110;
      SRC_TX:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_iir(src_e s, logic fifo_on);
    logic [REG_W-1:0] r;
    r        = '0;
    r[0]     = (s == SRC_NONE);
    r[3:1]   = id_bits(s);
    r[REG_W-1:REG_W-2] = {2{fifo_on}};
    return r;
  endfunction
endpackage

// File: rtl/uirq_pend_latch.sv
module uirq_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/uirq_rise.sv
module uirq_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/uirq_arbiter.sv
module uirq_arbiter
  import uirq_pkg::*;
(
  input  logic [EN_W-1:0] en_i,
  input  logic            fifo_on_i,
  input  logic            ls_i,
  input  logic            rx_i,
  input  logic            to_i,
  input  logic            tx_i,
  input  logic            ms_i,
  output src_e            sel_o
);
  always_comb begin
    if (ls_i && en_i[EB_LS])                    sel_o = SRC_LS;
    else if (rx_i && en_i[EB_RX])               sel_o = SRC_RX;
    else if (to_i && fifo_on_i && en_i[EB_RX])  sel_o = SRC_TO;
    else if (tx_i && en_i[EB_TX])               sel_o = SRC_TX;
    else if (ms_i && en_i[EB_MS])               sel_o = SRC_MS;
    else                                        sel_o = SRC_NONE;
  end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             ier_wr,
  input  logic [REG_W-1:0] ier_wdata,
  output logic [REG_W-1:0] ier_rdata,
  input  logic             ls_evt,
  input  logic             lsr_rd,
  input  logic             rx_level,
  input  logic             to_evt,
  input  logic             rbr_rd,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             ms_evt,
  input  logic             msr_rd,
  input  logic             iir_rd,
  output logic [REG_W-1:0] iir_rdata,
  input  logic             irq_gate,
  input  logic             loopback,
  output logic             irq_o,
  output logic             irq_oe
);
  logic [EN_W-1:0]   ier_q;
  logic [NLATCH-1:0] set_v, clr_v, pend_v;
  logic              tx_rise;
  logic              tx_ack;
  src_e              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata[EN_W-1:0];
  end
  assign ier_rdata = {{PAD_W{1'b0}}, ier_q};

  uirq_rise tx_edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(thr_empty), .rise_o(tx_rise)
  );

  // named internal event: an identification read that reports transmit empty
  assign tx_ack = iir_rd && (sel == SRC_TX);

  assign set_v[SL_LS] = ls_evt;
  assign set_v[SL_TO] = to_evt & fifo_mode;
  assign set_v[SL_TX] = tx_rise;
  assign set_v[SL_MS] = ms_evt;
  assign clr_v[SL_LS] = lsr_rd;
  assign clr_v[SL_TO] = rbr_rd;
  assign clr_v[SL_TX] = thr_wr | tx_ack;
  assign clr_v[SL_MS] = msr_rd;

  for (genvar g = 0; g < NLATCH; g++) begin : g_latch
    uirq_pend_latch latch_i (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_v[g]), .clr_i(clr_v[g]), .pend_o(pend_v[g])
    );
  end

  uirq_arbiter arb_i (
    .en_i(ier_q), .fifo_on_i(fifo_mode),
    .ls_i(pend_v[SL_LS]), .rx_i(rx_level), .to_i(pend_v[SL_TO]),
    .tx_i(pend_v[SL_TX]), .ms_i(pend_v[SL_MS]), .sel_o(sel)
  );

  assign iir_rdata = pack_iir(sel, fifo_mode);
  assign irq_o     = (sel != SRC_NONE);
  assign irq_oe    = irq_gate & ~loopback;

  // R5
  ls_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_evt |=> pend_v[SL_LS]);
  // R3
  ls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v[SL_LS] && ier_q[EB_LS]) |-> (iir_rdata[3:0] == 4'b0110));
  // R4
  no_to_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !iir_rdata[3]);
  // R7
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_rise) |=> !pend_v[SL_TX]);
  // R8
  ms_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ms_evt) |=> !pend_v[SL_MS]);
  // R10
  irq_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !iir_rdata[0]);
endmodule

// File: tb/uirq_ident_tb_top.sv
module uirq_ident_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 0, ier_wr = 0, ls_evt = 0, lsr_rd = 0, rx_level = 0;
  logic to_evt = 0, rbr_rd = 0, thr_empty = 0, thr_wr = 0, ms_evt = 0;
  logic msr_rd = 0, iir_rd = 0, irq_gate = 0, loopback = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] ier_rdata, iir_rdata;
  logic irq_o, irq_oe;

  int total = 0, bad = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  uirq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ier_wr(ier_wr),
    .ier_wdata(ier_wdata), .ier_rdata(ier_rdata), .ls_evt(ls_evt),
    .lsr_rd(lsr_rd), .rx_level(rx_level), .to_evt(to_evt), .rbr_rd(rbr_rd),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .ms_evt(ms_evt), .msr_rd(msr_rd),
    .iir_rd(iir_rd), .iir_rdata(iir_rdata), .irq_gate(irq_gate),
    .loopback(loopback), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // behavioural reference state
  bit m_ls, m_to, m_tx, m_ms, m_prev;
  bit [3:0] m_ier;

  function automatic logic [7:0] exp_iir();
    logic [7:0] v;
    v = {fifo_mode, fifo_mode, 6'b0};
    if (m_ls && m_ier[2])                      v[3:0] = 4'h6;
    else if (rx_level && m_ier[0])             v[3:0] = 4'h4;
    else if (m_to && fifo_mode && m_ier[0])    v[3:0] = 4'hC;
    else if (m_tx && m_ier[1])                 v[3:0] = 4'h2;
    else if (m_ms && m_ier[3])                 v[3:0] = 4'h0;
    else                                       v[3:0] = 4'h1;
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] pre;
    pre = exp_iir();
    if (!rst_n) begin
      m_ls = 0; m_to = 0; m_tx = 0; m_ms = 0; m_prev = 0; m_ier = 0;
    end else begin
      if (ls_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
      if (to_evt && fifo_mode) m_to = 1; else if (rbr_rd) m_to = 0;
      if (thr_empty && !m_prev) m_tx = 1;
      else if (thr_wr || (iir_rd && pre[3:0] == 4'h2)) m_tx = 0;
      if (ms_evt) m_ms = 1; else if (msr_rd) m_ms = 0;
      if (ier_wr) m_ier = ier_wdata[3:0];
      m_prev = thr_empty;
    end
    #2;
    if (rst_n && cmp_on) begin
      chk("R3 model iir", iir_rdata, exp_iir());
      chk("R2 model ier", ier_rdata, {4'b0, m_ier});
      chk("R10 model irq", {7'b0, irq_o}, {7'b0, exp_iir() ^ 8'h01} & 8'h01);
      chk("R10 model oe", {7'b0, irq_oe}, {7'b0, irq_gate & ~loopback});
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 ier reset", ier_rdata, 8'h00);
    chk("R1 iir reset", iir_rdata, 8'h01);
    chk("R1 irq reset", {7'b0, irq_o}, 8'h00);
    rst_n = 1; step();
    chk("R1 iir after release", iir_rdata, 8'h01);
    cmp_on = 1;

    // R2 enable write, upper bits read 0
    ier_wr = 1; ier_wdata = 8'hFF; step(); ier_wr = 0;
    chk("R2 ier upper zero", ier_rdata, 8'h0F);

    irq_gate = 1;
    // R5 / R3 error over modem
    ls_evt = 1; ms_evt = 1; step(); ls_evt = 0; ms_evt = 0;
    chk("R5 ls set", iir_rdata, 8'h06);
    chk("R10 irq high", {7'b0, irq_o}, 8'h01);
    chk("R10 oe high", {7'b0, irq_oe}, 8'h01);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R8 modem shown after ls clear", iir_rdata, 8'h00);
    msr_rd = 1; step(); msr_rd = 0;
    chk("R8 modem cleared", iir_rdata, 8'h01);

    // R6 data level, R3 data over tx
    rx_level = 1; #1;
    chk("R6 data level same cycle", iir_rdata, 8'h04);
    thr_empty = 1; step();
    chk("R3 data over tx", iir_rdata, 8'h04);
    // R7 iir read while data reported keeps tx
    iir_rd = 1; step(); iir_rd = 0;
    rx_level = 0; #1;
    chk("R7 tx kept after other read", iir_rdata, 8'h02);
    step();
    iir_rd = 1; step(); iir_rd = 0;
    chk("R7 tx cleared by iir read", iir_rdata, 8'h01);
    thr_empty = 0; step(); thr_empty = 1; step();
    chk("R7 tx re-raised", iir_rdata, 8'h02);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R7 tx cleared by write", iir_rdata, 8'h01);

    // R4 timeout in char mode ignored
    to_evt = 1; step(); to_evt = 0; step();
    chk("R4 char mode timeout ignored", iir_rdata, 8'h01);
    fifo_mode = 1; #1;
    chk("R11 fifo bits", iir_rdata, 8'hC1);
    to_evt = 1; step(); to_evt = 0;
    chk("R4 timeout code", iir_rdata, 8'hCC);
    rbr_rd = 1; step(); rbr_rd = 0;
    chk("R6 timeout cleared by rbr read", iir_rdata, 8'hC1);

    // R12 set and clear together
    ls_evt = 1; lsr_rd = 1; step(); ls_evt = 0; lsr_rd = 0;
    chk("R12 set wins", iir_rdata, 8'hC6);
    lsr_rd = 1; step(); lsr_rd = 0;

    // R9 disabled cause latches
    ier_wr = 1; ier_wdata = 8'h00; step(); ier_wr = 0;
    ls_evt = 1; step(); ls_evt = 0; step();
    chk("R9 disabled hidden", iir_rdata, 8'hC1);
    chk("R9 disabled no irq", {7'b0, irq_o}, 8'h00);
    ier_wr = 1; ier_wdata = 8'h04; step(); ier_wr = 0;
    chk("R9 revealed on enable", iir_rdata, 8'hC6);
    lsr_rd = 1; step(); lsr_rd = 0;

    // R10 loopback disconnects pin
    loopback = 1; #1;
    chk("R10 loopback oe", {7'b0, irq_oe}, 8'h00);
    loopback = 0; irq_gate = 0; #1;
    chk("R10 gate off oe", {7'b0, irq_oe}, 8'h00);

    // random phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      step();
      fifo_mode = ($urandom % 16) != 0;
      ier_wr    = ($urandom % 20) == 0;
      ier_wdata = 8'($urandom);
      ls_evt    = ($urandom % 10) == 0;
      lsr_rd    = ($urandom % 8) == 0;
      rx_level  = ($urandom % 5) == 0;
      to_evt    = ($urandom % 10) == 0;
      rbr_rd    = ($urandom % 8) == 0;
      thr_empty = ($urandom % 3) == 0;
      thr_wr    = ($urandom % 10) == 0;
      ms_evt    = ($urandom % 10) == 0;
      msr_rd    = ($urandom % 8) == 0;
      iir_rd    = ($urandom % 4) == 0;
      irq_gate  = ($urandom % 2) == 0;
      loopback  = ($urandom % 6) == 0;
    end
    step();
    ier_wr = 0; ls_evt = 0; to_evt = 0; ms_evt = 0;
    lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0; iir_rd = 0;
    repeat (3) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule